// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves data words from one clock domain to another through a 16-entry register array. The producer side writes on its own clock and sees a full flag. The consumer side reads on an unrelated clock and sees an empty flag. Each side has its own active-low asynchronous reset.

Each side counts with a 5-bit binary pointer. The low four bits select an array entry. The top bit flips each time the pointer passes the last entry, so a full array and an empty array can be told apart with no occupancy counter. Each pointer is re-encoded as Gray code in a register and crosses to the other side through a two-flop synchronizer. Full is judged in the write domain against the synchronized read pointer, and empty in the read domain against the synchronized write pointer. Both flags are registered.

The read port falls through: the oldest unread word sits on the data output whenever the empty flag is low, and a read strobe moves past it.

Top module: `gray_async_fifo`

## Requirements
- R1: After reset, `empty_o` is 1 and `full_o` is 0.
- R2: Words come out in the order they were written and without change. While `empty_o` is 0, `rd_data_o` shows the oldest unread word, and a read accepted at a read clock edge moves on to the next word.
- R3: With no reads, the FIFO holds exactly 16 words. `full_o` is still 0 after the 15th unread write, and it is 1 just after the write clock edge that stores the 16th word.
- R4: A write request while `full_o` is 1 is ignored. No word is stored, and the words already held come out unchanged.
- R5: A read request while `empty_o` is 1 is ignored. It consumes nothing, and the next word written is the next word read.
- R6: When all the written words are visible to the read side, `empty_o` becomes 1 just after the read clock edge that takes the last stored word.
- R7: The flags are conservative. `full_o` is never 0 while 16 words are stored. `empty_o` is never 0 while no word is stored.
- R8: A write becomes visible to the read side, so that `empty_o` clears, within 5 read clock cycles. A read frees space, so that `full_o` clears, within 5 write clock cycles. The pointers cross domains as Gray code and change by one bit at a time.
- R9: The FIFO works correctly across any number of pointer wraps. When both pointers address the same entry but their wrap bits differ, the state is full and not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write domain clock |
| wrst_ni | input | 1 | Write domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to write |
| full_o | output | 1 | No free entry, as seen from the write domain |
| rclk_i | input | 1 | Read domain clock |
| rrst_ni | input | 1 | Read domain asynchronous reset, active low |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Oldest unread word |
| empty_o | output | 1 | No unread word, as seen from the read domain |

## Verification
A write that fills the last free entry and a read that frees an entry can land in the same instant, and so can a read that takes the last word and a write that refills it. In both cases each flag has to stay on the safe side until the other pointer has crossed. The bench provokes this with unrelated clock periods and randomized enables. One phase runs writes much faster than reads, so the FIFO hovers at full. Another runs reads much faster than writes, so it hovers at empty. Requests go on being driven against a raised flag. A scoreboard judges every read for order and content, and at each sample it checks that a lowered flag agrees with the scoreboard's occupancy.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // flops in each cross-domain synchronizer
  localparam int unsigned SyncStages = 2;
  // extra pointer bits beyond the address, used to track wrap
  localparam int unsigned WrapBits = 1;
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import afifo_pkg::*;

  logic [W-1:0] stg_q [SyncStages];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SyncStages; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < SyncStages; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[SyncStages-1];
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // fall-through read
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/afifo_wptr.sv
module afifo_wptr #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned PTR_W = ADDR_W + afifo_pkg::WrapBits
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [PTR_W-1:0]  rgray_sync_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o,
  output logic              full_o
);
  logic [PTR_W-1:0] bin_q, bin_d, gray_d, full_pat;
  logic             full_d;

  assign push_o = req_i & ~full_o;
  assign bin_d  = bin_q + {{(PTR_W-1){1'b0}}, push_o};
  assign gray_d = bin_d ^ (bin_d >> 1);

  // Gray image of "read pointer one lap behind": top two bits inverted
  assign full_pat = {~rgray_sync_i[PTR_W-1:PTR_W-2], rgray_sync_i[PTR_W-3:0]};
  assign full_d   = (gray_d == full_pat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
      full_o <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_o <= gray_d;
      full_o <= full_d;
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];

  a_r4_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && req_i) |=> $stable(gray_o));

  a_r3_full_rises_on_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(push_o));

  a_r8_wgray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/afifo_rptr.sv
module afifo_rptr #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned PTR_W = ADDR_W + afifo_pkg::WrapBits
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [PTR_W-1:0]  wgray_sync_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o,
  output logic              empty_o
);
  logic [PTR_W-1:0] bin_q, bin_d, gray_d;
  logic             pop, empty_d;

  assign pop     = req_i & ~empty_o;
  assign bin_d   = bin_q + {{(PTR_W-1){1'b0}}, pop};
  assign gray_d  = bin_d ^ (bin_d >> 1);
  assign empty_d = (gray_d == wgray_sync_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q   <= '0;
      gray_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      bin_q   <= bin_d;
      gray_o  <= gray_d;
      empty_o <= empty_d;
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];

  a_r5_hold_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && req_i) |=> $stable(gray_o));

  a_r6_empty_rises_on_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(pop));

  a_r8_rgray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/gray_async_fifo.sv
module gray_async_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o
);
  localparam int unsigned PtrW = ADDR_W + afifo_pkg::WrapBits;

  logic              push;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PtrW-1:0]   wgray, rgray, wgray_sync, rgray_sync;

  afifo_wptr #(.ADDR_W(ADDR_W)) i_wptr (
    .clk_i        (wclk_i),
    .rst_ni       (wrst_ni),
    .req_i        (wr_en_i),
    .rgray_sync_i (rgray_sync),
    .push_o       (push),
    .addr_o       (waddr),
    .gray_o       (wgray),
    .full_o       (full_o)
  );

  afifo_rptr #(.ADDR_W(ADDR_W)) i_rptr (
    .clk_i        (rclk_i),
    .rst_ni       (rrst_ni),
    .req_i        (rd_en_i),
    .wgray_sync_i (wgray_sync),
    .addr_o       (raddr),
    .gray_o       (rgray),
    .empty_o      (empty_o)
  );

  afifo_sync #(.W(PtrW)) i_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (wrst_ni),
    .d_i    (rgray),
    .q_o    (rgray_sync)
  );

  afifo_sync #(.W(PtrW)) i_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rrst_ni),
    .d_i    (wgray),
    .q_o    (wgray_sync)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .wclk_i  (wclk_i),
    .we_i    (push),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );

  a_r1_reset_flags_w: assert property (@(posedge wclk_i)
    !wrst_ni |=> !full_o);
  a_r1_reset_flags_r: assert property (@(posedge rclk_i)
    !rrst_ni |=> empty_o);
endmodule

// File: tb/test_gray_async_fifo.sv
module test_gray_async_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic          wclk_i = 0, rclk_i = 0;
  logic          wrst_ni = 0, rrst_ni = 0;
  logic          wr_en_i = 0, rd_en_i = 0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          full_o, empty_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] q [$];

  always #2 wclk_i = ~wclk_i;  // 250 MHz
  always #3 rclk_i = ~rclk_i;

  gray_async_fifo #(.DATA_W(DW), .ADDR_W(4)) i_gray_async_fifo (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wclk_i);
    wr_en_i = 1; wr_data_i = d;
    if (!full_o) q.push_back(d);
    @(posedge wclk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic pop_word();
    @(negedge rclk_i);
    check(!empty_o, "R2 word available", empty_o, 0);
    if (q.size() > 0) begin
      check(rd_data_o == q[0], "R2 order/data", rd_data_o, q[0]);
      void'(q.pop_front());
    end
    rd_en_i = 1;
    @(posedge rclk_i); #1;
    rd_en_i = 0;
  endtask

  task automatic stream_wr(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk_i);
      if (!full_o) check(q.size() < DEPTH, "R7 full conservative", q.size(), DEPTH - 1);
      wr_en_i   = ($urandom % 100) < pct;
      wr_data_i = DW'($urandom);
      if (wr_en_i && !full_o) q.push_back(wr_data_i);  // R4: writes while full dropped
    end
    @(negedge wclk_i); wr_en_i = 0;
  endtask

  task automatic stream_rd(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk_i);
      if (!empty_o) check(q.size() > 0, "R7 empty conservative", q.size(), 1);
      rd_en_i = ($urandom % 100) < pct;
      if (rd_en_i && !empty_o && q.size() > 0) begin
        check(rd_data_o == q[0], "R2 stream data", rd_data_o, q[0]);
        void'(q.pop_front());
      end
    end
    @(negedge rclk_i); rd_en_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wclk_i);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge rclk_i);
    wrst_ni = 1; rrst_ni = 1;
    @(negedge wclk_i); #1;
    check(empty_o == 1, "R1 empty after reset", empty_o, 1);
    check(full_o == 0, "R1 full after reset", full_o, 0);

    // R5: reads on empty ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk_i); rd_en_i = 1;
    end
    @(negedge rclk_i); rd_en_i = 0;
    check(empty_o == 1, "R5 still empty", empty_o, 1);
    push_word(8'hA5);
    repeat (6) @(negedge rclk_i);
    check(empty_o == 0, "R8 write visible", empty_o, 0);
    pop_word();  // R5: first word read is the one written
    check(empty_o == 1, "R6 empty after last", empty_o, 1);

    // R3: fill to exactly 16
    repeat (8) @(negedge wclk_i);
    for (int i = 0; i < DEPTH; i++) begin
      push_word(DW'(8'h10 + i));
      check(full_o == (i == DEPTH - 1), "R3 full at 16", full_o, (i == DEPTH - 1));
    end
    // R4: writes while full dropped
    for (int i = 0; i < 3; i++) push_word(8'hEE);
    check(full_o == 1, "R4 full held", full_o, 1);
    check(q.size() == DEPTH, "R4 model depth", q.size(), DEPTH);
    repeat (6) @(negedge rclk_i);
    check(empty_o == 0, "R9 full is not empty", empty_o, 0);
    pop_word();
    repeat (6) @(negedge wclk_i);
    check(full_o == 0, "R8 read frees space", full_o, 0);
    while (q.size() > 0) begin
      pop_word();
      check(empty_o == (q.size() == 0), "R6 empty on last pop", empty_o, q.size() == 0);
    end

    // R9: rounds of varied size wrap the pointers several times
    for (int r = 0; r < 8; r++) begin
      int k;
      k = ((r * 7 + 5) % DEPTH) + 1;
      for (int i = 0; i < k; i++) push_word(DW'(r * 31 + i));
      repeat (6) @(negedge rclk_i);
      check(empty_o == 0, "R9 no false empty after wrap", empty_o, 0);
      check(full_o == (k == DEPTH), "R9 full after wrap", full_o, k == DEPTH);
      while (q.size() > 0) pop_word();
      check(empty_o == 1, "R9 drained", empty_o, 1);
    end

    // R7/R4/R5: concurrent stress near full then near empty
    fork
      stream_wr(3000, 90);
      stream_rd(2000, 40);
    join
    fork
      stream_wr(1500, 25);
      stream_rd(3000, 90);
    join
    repeat (6) @(negedge wclk_i);
    while (q.size() > 0) pop_word();
    repeat (6) @(negedge rclk_i);
    check(empty_o == 1, "R2 final empty", empty_o, 1);
    check(full_o == 0, "R8 final not full", full_o, 0);
    finish_run();
  end
endmodule